// File: doc/BRIEF.md
# Serial-In Parallel-Out Channel Driver Logic

This block decides the on/off state of a bank of output channels (32 by default) that drive display electrodes or print-head elements. A serial bit stream is clocked into a shift chain on the falling edge of a shift clock. The last stage is presented on a serial output so that several blocks can be chained into one long line. The channel outputs follow the chain stages directly, with no holding latch between them.

Two controls shape the channel outputs. An active-low strobe forces every channel on. An enable forces every channel off while it is low. The strobe wins when both are active. Neither control has any effect on shifting. A parameter reverses the mapping from chain stages to channel indices, so the same logic serves boards whose channels are filled in ascending order and boards filled in descending order. An active-low reset clears the chain. Its release is synchronised to the falling edge of the shift clock.

Top module: `sipo_channel_driver`

## Requirements
- R1: While `rst_n` is low, and after it is released, every chain stage is 0 until new bits are shifted in. The serial output is then 0, and with `strobe_n`=1 and `out_en`=1 every bit of `chan_on` is 0.
- R2: On each falling edge of `clk`, `ser_in` is captured into the first stage and every other stage takes the value of the stage before it. A rising edge changes nothing.
- R3: `ser_out` always equals the last chain stage. A bit shifted in appears on `ser_out` after exactly NCH falling edges.
- R4: When `strobe_n` is 0, every bit of `chan_on` is 1, whatever the values of `out_en` and the chain.
- R5: When `strobe_n` is 1 and `out_en` is 0, every bit of `chan_on` is 0, whatever the chain contents.
- R6: When `strobe_n` is 1 and `out_en` is 1, each `chan_on` bit equals its mapped chain stage. A value of 1 means the channel sinks current.
- R7: Shifting goes on unchanged whatever the values of `strobe_n` and `out_en`.
- R8: With REVERSE=0, `chan_on[i]` shows stage i, where stage 0 is the first stage. With REVERSE=1, `chan_on[i]` shows stage NCH-1-i.
- R9: When two blocks are chained through `ser_out` to `ser_in`, the first NCH bits of a 2*NCH-bit stream end up in the second block and the last NCH bits end up in the first block, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain moves on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released on a falling clock edge |
| ser_in | input | 1 | Serial data into the first stage |
| strobe_n | input | 1 | Active-low override that turns every channel on |
| out_en | input | 1 | Enable; when low, every channel is off unless the strobe is active |
| chan_on | output | NCH | Channel on/off states, 1 meaning on |
| ser_out | output | 1 | Last chain stage, for chaining to the next block |

## Verification
The all-on strobe and the all-off enable can be active in the same cycle, and either of them can coincide with a shift. The random phase changes the strobe, the enable and the serial bit together on every clock, so the override conflict and shifting under both overrides come up often. Directed steps also hold the strobe low with the enable low. In every cycle the bench compares both chained instances against a reference chain. It then releases both controls to confirm that the chain contents were not disturbed.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;
  localparam int unsigned DRV_DEFAULT_CH = 32;

  typedef enum logic [1:0] {
    GATE_ALL_OFF = 2'd0,
    GATE_FOLLOW  = 2'd1,
    GATE_ALL_ON  = 2'd2
  } gate_mode_e;
endpackage

// File: rtl/drv_rst_sync.sv
module drv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic meta_d;
  logic sync_q;
  logic sync_d;

  always_comb begin
    meta_d = 1'b1;
    sync_d = meta_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/drv_shift_chain.sv
module drv_shift_chain #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rst_sync_n,
  input  logic           ser_in,
  output logic [NCH-1:0] stage_q
);
  logic [NCH-1:0] stage_d;
  logic           shift_en;

  always_comb begin
    shift_en = 1'b1;
    stage_d  = stage_q;
    if (shift_en) stage_d = {stage_q[NCH-2:0], ser_in};
  end

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) stage_q <= '0;
    else             stage_q <= stage_d;
  end

  // R2: the first stage holds the bit present at the previous falling edge
  assert_first_stage_R2: assert property (@(negedge clk) disable iff (!rst_n)
    rst_sync_n |=> stage_q[0] == $past(ser_in));
  // R2: every later stage takes its neighbour's old value
  assert_chain_move_R2: assert property (@(negedge clk) disable iff (!rst_n)
    rst_sync_n |=> stage_q[NCH-1:1] == $past(stage_q[NCH-2:0]));
  // R1: the chain stays clear while the synchronised reset is held
  assert_reset_clear_R1: assert property (@(negedge clk) disable iff (!rst_n)
    !rst_sync_n |=> stage_q == '0);
endmodule

// File: rtl/drv_chan_gate.sv
module drv_chan_gate
  import sipo_drv_pkg::*;
#(
  parameter int unsigned NCH     = 32,
  parameter bit          REVERSE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] stage_q,
  input  logic           strobe_n,
  input  logic           out_en,
  output logic [NCH-1:0] chan_on
);
  logic [NCH-1:0] mapped;
  gate_mode_e     mode;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_map
      if (REVERSE) begin : g_rev
        assign mapped[i] = stage_q[NCH-1-i];
      end else begin : g_fwd
        assign mapped[i] = stage_q[i];
      end
    end
  endgenerate

  always_comb begin
    if (!strobe_n)   mode = GATE_ALL_ON;
    else if (out_en) mode = GATE_FOLLOW;
    else             mode = GATE_ALL_OFF;
  end

  always_comb begin
    unique case (mode)
      GATE_ALL_ON: chan_on = '1;
      GATE_FOLLOW: chan_on = mapped;
      default:     chan_on = '0;
    endcase
  end

  // R4: the strobe override turns every channel on, even with the enable low
  assert_strobe_all_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> &chan_on);
  // R5: the enable low with no strobe leaves every channel off
  assert_enable_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && !out_en) |-> chan_on == '0);
endmodule

// File: rtl/sipo_channel_driver.sv
module sipo_channel_driver
  import sipo_drv_pkg::*;
#(
  parameter int unsigned NCH     = DRV_DEFAULT_CH,
  parameter bit          REVERSE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_in,
  input  logic           strobe_n,
  input  logic           out_en,
  output logic [NCH-1:0] chan_on,
  output logic           ser_out
);
  localparam int unsigned LAST_CH = REVERSE ? 0 : NCH - 1;

  logic           rst_sync_n;
  logic [NCH-1:0] stage_q;

  drv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  drv_shift_chain #(.NCH(NCH)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .ser_in     (ser_in),
    .stage_q    (stage_q)
  );

  drv_chan_gate #(.NCH(NCH), .REVERSE(REVERSE)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_q  (stage_q),
    .strobe_n (strobe_n),
    .out_en   (out_en),
    .chan_on  (chan_on)
  );

  assign ser_out = stage_q[NCH-1];

  // R3 R8: with channels following the chain, the channel mapped to the last stage matches ser_out
  assert_cascade_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && out_en) |-> chan_on[LAST_CH] == ser_out);
  // R1: the cascade output is low while the chain is held in reset
  assert_reset_ser_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync_n |-> !ser_out);
endmodule

// File: tb/tb_sipo_channel_driver.sv
module tb_sipo_channel_driver;
  localparam int unsigned NCH = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ser_in = 1'b0;
  logic           strobe_n = 1'b1;
  logic           out_en = 1'b1;
  logic [NCH-1:0] chan_a;
  logic [NCH-1:0] chan_b;
  logic           ser_a;
  logic           ser_b;

  logic [NCH-1:0] ref_a = '0;
  logic [NCH-1:0] ref_b = '0;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sipo_channel_driver #(.NCH(NCH), .REVERSE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe_n(strobe_n),
    .out_en(out_en), .chan_on(chan_a), .ser_out(ser_a));

  sipo_channel_driver #(.NCH(NCH), .REVERSE(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_a), .strobe_n(strobe_n),
    .out_en(out_en), .chan_on(chan_b), .ser_out(ser_b));

  function automatic logic [NCH-1:0] rev_bits(input logic [NCH-1:0] v);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = v[NCH-1-i];
    return r;
  endfunction

  function automatic logic [NCH-1:0] exp_chan(input logic [NCH-1:0] st,
                                              input logic s_n, input logic en,
                                              input bit rev);
    if (!s_n) return '1;
    if (!en)  return '0;
    return rev ? rev_bits(st) : st;
  endfunction

  task automatic chk(input string req, input logic [NCH-1:0] act,
                     input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, chan_a, exp_chan(ref_a, strobe_n, out_en, 1'b0));
    chk(req, chan_b, exp_chan(ref_b, strobe_n, out_en, 1'b1));
    chk({req, " R3 ser_out"}, {{(NCH-1){1'b0}}, ser_a}, {{(NCH-1){1'b0}}, ref_a[NCH-1]});
    chk({req, " R3 ser_out b"}, {{(NCH-1){1'b0}}, ser_b}, {{(NCH-1){1'b0}}, ref_b[NCH-1]});
  endtask

  // drive away from the falling edge, update the model at that edge, check after it
  task automatic step(input logic b, input logic s_n, input logic en,
                      input string req);
    ser_in = b; strobe_n = s_n; out_en = en;
    @(negedge clk);
    ref_b = {ref_b[NCH-2:0], ref_a[NCH-1]};
    ref_a = {ref_a[NCH-2:0], b};
    #2;
    check_all(req);
  endtask

  initial begin
    #(10 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2*NCH-1:0] pat;
    void'($urandom(32'h5A17));
    #3;
    check_all("R1 during reset");
    chk("R1 chan all off in reset", chan_a, '0);
    #20 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check_all("R1 after release");
    chk("R1 chan zero", chan_a, '0);

    // R2: a rising edge alone does not shift
    ser_in = 1'b1;
    @(posedge clk); #2;
    chk("R2 no shift on rising edge", chan_a, '0);
    step(1'b1, 1'b1, 1'b1, "R2 single shift");
    chk("R2 first stage", chan_a, {{(NCH-1){1'b0}}, 1'b1});
    chk("R8 reverse mapping top", chan_b, '0);
    // R3: that bit reaches ser_out after NCH edges in total
    for (int k = 1; k < NCH; k++) step(1'b0, 1'b1, 1'b1, "R3 walk");
    chk("R3 ser_out after NCH", {{(NCH-1){1'b0}}, ser_a}, {{(NCH-1){1'b0}}, 1'b1});
    step(1'b0, 1'b1, 1'b1, "R8 reverse first");
    chk("R8 reverse stage0 on chan top", chan_b, {1'b1, {(NCH-1){1'b0}}});

    // R4 R5 conflict: strobe low with enable low while shifting
    step(1'b1, 1'b0, 1'b0, "R4 strobe over enable");
    step(1'b1, 1'b0, 1'b1, "R4 strobe with enable");
    step(1'b0, 1'b1, 1'b0, "R5 enable off");
    step(1'b1, 1'b1, 1'b1, "R6 follow after overrides R7");

    // random phase: controls change every cycle alongside shifting
    for (int n = 0; n < 400; n++) begin
      logic [2:0] r;
      r = 3'($urandom);
      step(r[0], r[1] | (n[3] & r[2]), r[2], "R4 R5 R6 R7 random");
    end

    // R9: 2*NCH-bit pattern through the pair
    pat = {$urandom, $urandom};
    for (int k = 2*NCH-1; k >= 0; k--) step(pat[k], 1'b1, 1'b0, "R9 load");
    strobe_n = 1'b1; out_en = 1'b1; #1;
    chk("R9 first block holds later half", chan_a, pat[NCH-1:0]);
    chk("R9 second block holds first half", chan_b, rev_bits(pat[2*NCH-1:NCH]));
    chk("R7 chain intact after off phase", chan_a, ref_a);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule